// File: doc/BRIEF.md
# Brown-out Reset Sequencer

This block turns the digital output of an undervoltage comparator into a device reset. The comparator flag is brought into the clock domain through a two-flop synchronizer. A dip counts only once it lasts a minimum number of cycles. A 2-bit configuration field selects one of four enable modes: off, under software control, active except during sleep, or always active.

Once reset is asserted, it stays asserted until the supply recovers. An optional power-up delay can then extend reset by a fixed number of cycles. A new dip during that delay sends the block back to the brown-out state, and the delay starts again from zero.

Software can write two status flags and a software enable bit. The brown-out flag is cleared on every brown-out event. The power-on flag and the brown-out flag are both cleared by a power-on pulse. Software sets both flags after power-on; if the brown-out flag later reads 0 while the power-on flag still reads 1, the reset came from a brown-out. The threshold selection goes straight from configuration to the analog side, and software has no write path to it.

Top module: `brownout_seq`

## Requirements
- R1: With `cfgEnMode` = 00, detection is off and no dip of any length asserts `resetOut`.
- R2: With `cfgEnMode` = 01, detection follows the stored software enable bit (`regWrData[2]`): a long dip asserts reset when the bit is 1 and does nothing when it is 0.
- R3: `swEnableRd` shows the stored software enable bit only while `cfgEnMode` = 01 and reads 0 in every other mode; the stored value survives a mode change.
- R4: With `cfgEnMode` = 10, detection is active while `sleepMode` = 0 and disabled while `sleepMode` = 1.
- R5: With `cfgEnMode` = 11, detection is active regardless of `sleepMode` and of the software enable bit.
- R6: `lowSupply` passes through two flops. `resetOut` rises after `lowSupply` has been sampled high on DIP_CYCLES consecutive rising edges (plus the two synchronizer edges). A dip sampled on fewer edges causes no reset.
- R7: Once in brown-out, reset holds while the synchronized flag is high. With the timer off, `resetOut` falls on the third rising edge at which `lowSupply` is sampled low.
- R8: With `cfgTimerEn` = 1, reset is held for PWRT_CYCLES more cycles after recovery, so it falls on edge PWRT_CYCLES+3 after the drop. The timer enable does not turn detection on.
- R9: A dip that reaches the synchronizer output during the power-up delay returns the block to brown-out and restarts the delay from zero after the next recovery.
- R10: A write (`regWrEn`) loads `regWrData` as bit0 brown-out flag, bit1 power-on flag, bit2 software enable. Every brown-out entry clears the brown-out flag and leaves the power-on flag unchanged.
- R11: While `porPulse` is high, `resetOut` is high. A power-on pulse clears both status flags and the software enable bit and returns the sequencer to run.
- R12: `thresholdSel` always equals `cfgThreshSel`; register writes never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porPulse | input | 1 | Power-on event, active high, synchronous |
| lowSupply | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| sleepMode | input | 1 | Device is in sleep |
| cfgEnMode | input | 2 | Enable mode: 00 off, 01 software, 10 awake only, 11 always |
| cfgThreshSel | input | 2 | Configured threshold selection |
| cfgTimerEn | input | 1 | Power-up delay timer enable |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 3 | Write data: bit0 brown-out flag, bit1 power-on flag, bit2 software enable |
| resetOut | output | 1 | Device reset, active high |
| thresholdSel | output | 2 | Threshold selection to the comparator |
| swEnableRd | output | 1 | Read view of the software enable bit |
| borFlag | output | 1 | Brown-out status flag |
| porFlag | output | 1 | Power-on status flag |

## Verification
The bench builds the block with DIP_CYCLES = 4 and PWRT_CYCLES = 8. These small values let the bench probe both sides of the filter threshold exactly, with a 3-edge dip against a 4-edge dip. They also let it step through a whole power-up delay, including a restart partway through, with cycle-exact checks on the release edge. Because the values are small, every enable mode and sleep combination fits into one short table walk.

// File: rtl/brownout_seq_pkg.sv
package brownout_seq_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_BROWN, ST_DELAY} seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic borEvent;
  } seqStrobe_t;

  localparam logic [1:0] MODE_OFF     = 2'b00;
  localparam logic [1:0] MODE_SW      = 2'b01;
  localparam logic [1:0] MODE_AWAKE   = 2'b10;
  localparam logic [1:0] MODE_ALWAYS  = 2'b11;
endpackage

// File: rtl/brownout_seq_datapath.sv
module brownout_seq_datapath
  import brownout_seq_pkg::*;
#(
  parameter int DIP_CYCLES  = 16,
  parameter int PWRT_CYCLES = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porPulse,
  input  logic       lowSupply,
  input  logic       sleepMode,
  input  logic [1:0] cfgEnMode,
  input  logic       regWrEn,
  input  logic [2:0] regWrData,
  input  seqStrobe_t strobe,
  output logic       lowSync,
  output logic       detectEn,
  output logic       dipDone,
  output logic       delayDone,
  output logic       swEnableRd,
  output logic       borFlag,
  output logic       porFlag
);
  localparam int CNT_MAX = (DIP_CYCLES > PWRT_CYCLES) ? DIP_CYCLES : PWRT_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CW-1:0]          cnt;
  logic                   swEnReg;

  // comparator flag resynchronisation
  always_ff @(posedge clk) begin
    if (porPulse) syncChain <= '0;
    else          syncChain <= {syncChain[SYNC_STAGES-2:0], lowSupply};
  end
  assign lowSync = syncChain[SYNC_STAGES-1];

  // shared duration counter: dip filter and power-up delay
  always_ff @(posedge clk) begin
    if (porPulse || strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc)        cnt <= cnt + 1'b1;
  end
  assign dipDone   = (cnt == CW'(DIP_CYCLES - 1));
  assign delayDone = (cnt == CW'(PWRT_CYCLES - 1));

  always_comb begin
    unique case (cfgEnMode)
      MODE_OFF:    detectEn = 1'b0;
      MODE_SW:     detectEn = swEnReg;
      MODE_AWAKE:  detectEn = !sleepMode;
      default:     detectEn = 1'b1;
    endcase
  end

  // status flags and software enable
  always_ff @(posedge clk) begin
    if (porPulse) begin
      swEnReg <= 1'b0;
      borFlag <= 1'b0;
      porFlag <= 1'b0;
    end else begin
      if (regWrEn) begin
        swEnReg <= regWrData[2];
        porFlag <= regWrData[1];
        borFlag <= regWrData[0];
      end
      if (strobe.borEvent) borFlag <= 1'b0;
    end
  end
  assign swEnableRd = (cfgEnMode == MODE_SW) && swEnReg;

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (porPulse)
    cnt <= CW'(CNT_MAX - 1));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (porPulse)
    strobe.borEvent |=> !borFlag);

  assert_por_keep_R10: assert property (@(posedge clk) disable iff (porPulse)
    (strobe.borEvent && !regWrEn) |=> $stable(porFlag));
endmodule

// File: rtl/brownout_seq_control.sv
module brownout_seq_control
  import brownout_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porPulse,
  input  logic       lowSync,
  input  logic       detectEn,
  input  logic       dipDone,
  input  logic       delayDone,
  input  logic       timerEn,
  input  logic [1:0] cfgEnMode,
  output seqStrobe_t strobe,
  output logic       resetOut
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (porPulse) state <= ST_RUN;
    else          state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_RUN: begin
        if (lowSync && detectEn) begin
          if (dipDone) begin
            stateNext       = ST_BROWN;
            strobe.cntClr   = 1'b1;
            strobe.borEvent = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end else begin
          strobe.cntClr = 1'b1;
        end
      end
      ST_BROWN: begin
        strobe.cntClr = 1'b1;
        if (!lowSync) stateNext = timerEn ? ST_DELAY : ST_RUN;
      end
      ST_DELAY: begin
        if (lowSync) begin
          stateNext       = ST_BROWN;
          strobe.cntClr   = 1'b1;
          strobe.borEvent = 1'b1;
        end else if (delayDone) begin
          stateNext     = ST_RUN;
          strobe.cntClr = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: begin
        stateNext     = ST_RUN;
        strobe.cntClr = 1'b1;
      end
    endcase
  end

  assign resetOut = porPulse || (state != ST_RUN);

  assert_mode_off_R1: assert property (@(posedge clk) disable iff (porPulse)
    (cfgEnMode == MODE_OFF && state == ST_RUN) |=> !resetOut);

  assert_hold_R7: assert property (@(posedge clk) disable iff (porPulse)
    (state == ST_BROWN && lowSync) |=> resetOut);

  assert_timer_start_R8: assert property (@(posedge clk) disable iff (porPulse)
    (state == ST_BROWN && !lowSync && timerEn) |=> (state == ST_DELAY));

  assert_restart_R9: assert property (@(posedge clk) disable iff (porPulse)
    (state == ST_DELAY && lowSync) |=> (state == ST_BROWN));
endmodule

// File: rtl/brownout_seq.sv
module brownout_seq
  import brownout_seq_pkg::*;
#(
  parameter int DIP_CYCLES  = 16,
  parameter int PWRT_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       porPulse,
  input  logic       lowSupply,
  input  logic       sleepMode,
  input  logic [1:0] cfgEnMode,
  input  logic [1:0] cfgThreshSel,
  input  logic       cfgTimerEn,
  input  logic       regWrEn,
  input  logic [2:0] regWrData,
  output logic       resetOut,
  output logic [1:0] thresholdSel,
  output logic       swEnableRd,
  output logic       borFlag,
  output logic       porFlag
);
  seqStrobe_t strobe;
  logic lowSync, detectEn, dipDone, delayDone;

  brownout_seq_datapath #(
    .DIP_CYCLES (DIP_CYCLES),
    .PWRT_CYCLES(PWRT_CYCLES),
    .SYNC_STAGES(2)
  ) uDatapath (
    .clk       (clk),
    .porPulse  (porPulse),
    .lowSupply (lowSupply),
    .sleepMode (sleepMode),
    .cfgEnMode (cfgEnMode),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe),
    .lowSync   (lowSync),
    .detectEn  (detectEn),
    .dipDone   (dipDone),
    .delayDone (delayDone),
    .swEnableRd(swEnableRd),
    .borFlag   (borFlag),
    .porFlag   (porFlag)
  );

  brownout_seq_control uControl (
    .clk      (clk),
    .porPulse (porPulse),
    .lowSync  (lowSync),
    .detectEn (detectEn),
    .dipDone  (dipDone),
    .delayDone(delayDone),
    .timerEn  (cfgTimerEn),
    .cfgEnMode(cfgEnMode),
    .strobe   (strobe),
    .resetOut (resetOut)
  );

  // threshold comes from configuration only (R12)
  assign thresholdSel = cfgThreshSel;
endmodule

// File: tb/tb_brownout_seq.sv
`timescale 1ns/1ps
module tb_brownout_seq;
  localparam int DIP  = 4;
  localparam int PWRT = 8;

  logic       clk = 1'b0;
  logic       porPulse = 1'b1;
  logic       lowSupply = 1'b0;
  logic       sleepMode = 1'b0;
  logic [1:0] cfgEnMode = 2'b11;
  logic [1:0] cfgThreshSel = 2'b00;
  logic       cfgTimerEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regWrData = 3'b000;
  logic       resetOut, swEnableRd, borFlag, porFlag;
  logic [1:0] thresholdSel;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  brownout_seq #(.DIP_CYCLES(DIP), .PWRT_CYCLES(PWRT)) dut (
    .clk(clk), .porPulse(porPulse), .lowSupply(lowSupply), .sleepMode(sleepMode),
    .cfgEnMode(cfgEnMode), .cfgThreshSel(cfgThreshSel), .cfgTimerEn(cfgTimerEn),
    .regWrEn(regWrEn), .regWrData(regWrData), .resetOut(resetOut),
    .thresholdSel(thresholdSel), .swEnableRd(swEnableRd), .borFlag(borFlag),
    .porFlag(porFlag)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       sleep;
    logic       sw;
    logic [7:0] len;
    logic       expRst;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b11, 1'b0, 1'b0, 8'd4,  1'b1},
    '{2'b11, 1'b0, 1'b0, 8'd3,  1'b0},
    '{2'b00, 1'b0, 1'b1, 8'd10, 1'b0},
    '{2'b01, 1'b0, 1'b1, 8'd6,  1'b1},
    '{2'b01, 1'b0, 1'b0, 8'd6,  1'b0},
    '{2'b10, 1'b0, 1'b0, 8'd5,  1'b1},
    '{2'b10, 1'b1, 1'b0, 8'd8,  1'b0},
    '{2'b11, 1'b1, 1'b0, 8'd5,  1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doPor();
    porPulse = 1'b1;
    tick(2);
    porPulse = 1'b0;
    tick(1);
  endtask

  task automatic regWrite(input logic [2:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic dip(input int len);
    lowSupply = 1'b1;
    tick(len);
    lowSupply = 1'b0;
  endtask

  function automatic string tagFor(input vec_t v);
    case (v.mode)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R4";
      default: return (v.len < DIP) ? "R6" : "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    tick(1);
    // R11: reset held during power-on
    check("R11 reset during por", resetOut, 1);
    porPulse = 1'b0;
    tick(1);
    check("R11 reset released after por", resetOut, 0);

    // table walk: mode, sleep, software enable, dip length
    foreach (VECS[i]) begin
      cfgEnMode  = VECS[i].mode;
      sleepMode  = VECS[i].sleep;
      cfgTimerEn = 1'b0;
      doPor();
      regWrite({VECS[i].sw, 2'b11});
      tick(1);
      dip(int'(VECS[i].len));
      tick(2);
      check(tagFor(VECS[i]), resetOut, VECS[i].expRst);
      tick(4);
      check("R7 released after recovery", resetOut, 0);
      check("R10 bor flag", borFlag, !VECS[i].expRst);
      check("R10 por flag kept", porFlag, 1);
    end
    sleepMode = 1'b0;

    // R3: read view gated by mode, stored value kept
    cfgEnMode = 2'b01;
    doPor();
    regWrite(3'b111);
    check("R3 visible in mode 01", swEnableRd, 1);
    cfgEnMode = 2'b11;
    tick(1);
    check("R3 hidden in mode 11", swEnableRd, 0);
    cfgEnMode = 2'b01;
    tick(1);
    check("R3 value kept", swEnableRd, 1);

    // R11: power-on clears flags and software enable
    porPulse = 1'b1;
    tick(1);
    check("R11 bor cleared", borFlag, 0);
    check("R11 por cleared", porFlag, 0);
    check("R11 sw enable cleared", swEnableRd, 0);
    porPulse = 1'b0;
    tick(1);

    // R12: threshold follows configuration only
    cfgThreshSel = 2'b10;
    regWrite(3'b111);
    check("R12 threshold", thresholdSel, 2'b10);

    // R7: exact release edge with timer off
    cfgEnMode = 2'b11;
    cfgTimerEn = 1'b0;
    doPor();
    dip(6);
    tick(2);
    check("R7 held before third low edge", resetOut, 1);
    tick(1);
    check("R7 released on third low edge", resetOut, 0);

    // R8: power-up delay length
    cfgTimerEn = 1'b1;
    doPor();
    dip(6);
    tick(2);
    check("R8 in brown-out", resetOut, 1);
    tick(PWRT);
    check("R8 held through delay", resetOut, 1);
    tick(1);
    check("R8 released after delay", resetOut, 0);

    // R8: timer enable alone does not enable detection
    cfgEnMode = 2'b00;
    doPor();
    dip(10);
    tick(2);
    check("R8 timer independent of detection", resetOut, 0);

    // R9: dip during delay restarts it
    cfgEnMode = 2'b11;
    doPor();
    dip(6);
    tick(2);
    tick(3);
    check("R9 in delay", resetOut, 1);
    dip(2);
    tick(PWRT + 2);
    check("R9 delay restarted", resetOut, 1);
    tick(1);
    check("R9 released after restarted delay", resetOut, 0);
    check("R9 bor flag cleared by re-entry", borFlag, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule